// File: doc/BRIEF.md
# Qualified Chip-Select with Wait-State Acknowledge

This block drives one active-low chip-select for an external bus channel. An address comparator elsewhere reports a match. The block then checks the cycle's direction, its byte lanes and the chosen strobe against the channel's option fields. It asserts the chip-select only when every qualifier agrees.

Two timing schemes are offered. In the asynchronous scheme the chip-select follows either the address strobe or the data strobe, and the block produces its own data-and-size acknowledge after a programmed number of wait states. A fast-termination code acknowledges together with the chip-select, and one code leaves the acknowledge to the external device. In the synchronous scheme the block tells the bus interface that an E-clock cycle is pending, and it asserts the chip-select only while the E-clock phase is high. In this scheme it never acknowledges on its own.

All outputs are registered: each reflects the inputs sampled at the previous rising clock edge. The option fields are plain inputs and are held by the surrounding register file.

Top module: `chip_sel_opt`

## Requirements
- R1: While `rstN` is low, `csN` is 1, `ackN` is 1 and `eclkReq` is 0.
- R2: The direction field `optRw` gates the chip-select: 2'b00 never asserts, 2'b01 asserts only when `rdWr`=1 (read), 2'b10 only when `rdWr`=0 (write), 2'b11 for both.
- R3: With `port16`=1, the lane field `optByte` gates the chip-select against `byteLanes` (bit 0 lower lane, bit 1 upper lane): 2'b00 never asserts, 2'b01 needs bit 0, 2'b10 needs bit 1, 2'b11 needs either bit.
- R4: With `port16`=0, `optByte` has no effect; only the match, the direction field and the strobe decide.
- R5: In asynchronous mode (`optSync`=0), the strobe is `asN` when `optStrobe`=0 and `dsN` when `optStrobe`=1. `csN` goes low one edge after a cycle that is qualified with the selected strobe low. It goes high one edge after the selected strobe negates or qualification is lost.
- R6: In asynchronous mode, an acknowledge code W from 0 to 13 drives `ackN` low W+1 edges after the edge that lowered `csN`. `ackN` stays low until `csN` rises.
- R7: In asynchronous mode, acknowledge code 4'b1110 (fast termination) drives `ackN` low on the same edge that lowers `csN`.
- R8: Acknowledge code 4'b1111 never drives `ackN` low.
- R9: In synchronous mode (`optSync`=1), `csN` goes low one edge after a qualified cycle with `asN` low and `eclkPhase` high. `ackN` stays 1 whatever the acknowledge code.
- R10: `eclkReq` goes high one edge after a qualified cycle with `asN` low in synchronous mode. In asynchronous mode it stays 0.
- R11: `ackN` is never low while `csN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| addrHit | input | 1 | Address match from the base/range comparator |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 1 | Data strobe, active low |
| rdWr | input | 1 | 1 = read, 0 = write |
| byteLanes | input | 2 | Active lanes of the cycle, bit 1 upper, bit 0 lower |
| eclkPhase | input | 1 | High during the active E-clock phase |
| port16 | input | 1 | Channel is wired as a 16-bit port |
| optSync | input | 1 | 0 asynchronous, 1 E-clock synchronous |
| optByte | input | 2 | Lane select field |
| optRw | input | 2 | Direction qualifier field |
| optStrobe | input | 1 | 0 address strobe, 1 data strobe |
| optAck | input | CODE_W | Acknowledge / wait-state code |
| csN | output | 1 | Chip-select, active low |
| ackN | output | 1 | Internal data-and-size acknowledge, active low |
| eclkReq | output | 1 | E-clock cycle pending |

## Verification
The bench uses the default `CODE_W` of 4, so the acknowledge code has sixteen values. Strobe holds of up to eighteen cycles are enough to reach the longest wait of thirteen states, and the fast-termination and external codes also come up. With this width the wait counter saturates just above the largest wait it must measure. The bench therefore also covers the long holds where the counter stays pinned at its limit while the acknowledge remains asserted.

// File: rtl/chip_sel_pkg.sv
package chip_sel_pkg;
  // Strobes from the qualifier control to the timing datapath
  typedef struct packed {
    logic goAsync;     // qualified async cycle with its strobe active
    logic goSync;      // qualified sync cycle inside the E-clock phase
    logic syncReq;     // qualified sync cycle, E-clock access pending
    logic ackInternal; // async mode with an internally generated ack
    logic fastTerm;    // fast-termination code selected
  } csStrobe_t;
endpackage

// File: rtl/chip_sel_ctrl.sv
module chip_sel_ctrl
  import chip_sel_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              addrHit,
  input  logic              asN,
  input  logic              dsN,
  input  logic              rdWr,
  input  logic [1:0]        byteLanes,
  input  logic              eclkPhase,
  input  logic              port16,
  input  logic              optSync,
  input  logic [1:0]        optByte,
  input  logic [1:0]        optRw,
  input  logic              optStrobe,
  input  logic [CODE_W-1:0] optAck,
  output csStrobe_t         strobes
);
  localparam logic [CODE_W-1:0] CODE_EXT  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_FAST = CODE_EXT - 1'b1;

  logic rwOk, laneOk, qualified, strobeLive;

  always_comb begin
    unique case (optRw)
      2'b01:   rwOk = rdWr;
      2'b10:   rwOk = ~rdWr;
      2'b11:   rwOk = 1'b1;
      default: rwOk = 1'b0;
    endcase
  end

  always_comb begin
    if (!port16) begin
      laneOk = 1'b1;
    end else begin
      unique case (optByte)
        2'b01:   laneOk = byteLanes[0];
        2'b10:   laneOk = byteLanes[1];
        2'b11:   laneOk = |byteLanes;
        default: laneOk = 1'b0;
      endcase
    end
  end

  assign qualified  = addrHit & rwOk & laneOk;
  assign strobeLive = optStrobe ? ~dsN : ~asN;

  always_comb begin
    strobes.goAsync     = ~optSync & qualified & strobeLive;
    strobes.syncReq     = optSync & qualified & ~asN;
    strobes.goSync      = optSync & qualified & ~asN & eclkPhase;
    strobes.ackInternal = ~optSync & (optAck != CODE_EXT);
    strobes.fastTerm    = (optAck == CODE_FAST);
  end
endmodule

// File: rtl/chip_sel_dp.sv
module chip_sel_dp
  import chip_sel_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  csStrobe_t         strobes,
  input  logic [CODE_W-1:0] optAck,
  output logic              csN,
  output logic              ackN,
  output logic              eclkReq
);
  localparam logic [CODE_W-1:0] CNT_MAX = {CODE_W{1'b1}};

  logic              activeQ;
  logic [CODE_W-1:0] waitCnt;
  logic [CODE_W-1:0] elapsed;
  logic              cycStart;
  logic              ackHit;

  assign cycStart = strobes.goAsync & ~activeQ;

  always_comb begin
    if (cycStart)
      elapsed = '0;
    else if (waitCnt == CNT_MAX)
      elapsed = CNT_MAX;
    else
      elapsed = waitCnt + 1'b1;
  end

  assign ackHit = strobes.fastTerm |
                  ({1'b0, elapsed} >= ({1'b0, optAck} + (CODE_W+1)'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      waitCnt <= '0;
      csN     <= 1'b1;
      ackN    <= 1'b1;
      eclkReq <= 1'b0;
    end else begin
      activeQ <= strobes.goAsync;
      waitCnt <= strobes.goAsync ? elapsed : '0;
      csN     <= ~(strobes.goAsync | strobes.goSync);
      ackN    <= ~(strobes.goAsync & strobes.ackInternal & ackHit);
      eclkReq <= strobes.syncReq;
    end
  end

  // R11: acknowledge only inside an asserted chip-select
  a_r11_ack_inside_cs: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |-> !csN);

  // R7: fast termination acknowledges with the chip-select
  a_r7_fast_with_cs: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.goAsync && strobes.ackInternal && strobes.fastTerm) |=> (!ackN && !csN));

  // R9: no internal acknowledge for a synchronous access
  a_r9_sync_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    strobes.goSync |=> (ackN && !csN));
endmodule

// File: rtl/chip_sel_opt.sv
module chip_sel_opt
  import chip_sel_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrHit,
  input  logic              asN,
  input  logic              dsN,
  input  logic              rdWr,
  input  logic [1:0]        byteLanes,
  input  logic              eclkPhase,
  input  logic              port16,
  input  logic              optSync,
  input  logic [1:0]        optByte,
  input  logic [1:0]        optRw,
  input  logic              optStrobe,
  input  logic [CODE_W-1:0] optAck,
  output logic              csN,
  output logic              ackN,
  output logic              eclkReq
);
  csStrobe_t strobes;

  chip_sel_ctrl #(.CODE_W(CODE_W)) i_ctrl (
    .addrHit(addrHit), .asN(asN), .dsN(dsN), .rdWr(rdWr),
    .byteLanes(byteLanes), .eclkPhase(eclkPhase), .port16(port16),
    .optSync(optSync), .optByte(optByte), .optRw(optRw),
    .optStrobe(optStrobe), .optAck(optAck), .strobes(strobes)
  );

  chip_sel_dp #(.CODE_W(CODE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .optAck(optAck),
    .csN(csN), .ackN(ackN), .eclkReq(eclkReq)
  );

  // R2: reserved direction code keeps the chip-select off
  a_r2_rw_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (optRw == 2'b00) |=> csN);

  // R3: lane field 00 on a 16-bit port keeps the chip-select off
  a_r3_lane_off: assert property (@(posedge clk) disable iff (!rstN)
    (port16 && optByte == 2'b00) |=> csN);

  // R8: external-acknowledge code never acknowledges internally
  a_r8_ext_ack: assert property (@(posedge clk) disable iff (!rstN)
    (optAck == {CODE_W{1'b1}}) |=> ackN);

  // R10: no pending E-clock flag in asynchronous mode
  a_r10_no_req_async: assert property (@(posedge clk) disable iff (!rstN)
    !optSync |=> !eclkReq);
endmodule

// File: tb/test_chip_sel_opt.sv
module test_chip_sel_opt;
  localparam int CODE_W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, addrHit, asN, dsN, rdWr, eclkPhase, port16;
  logic optSync, optStrobe;
  logic [1:0] byteLanes, optByte, optRw;
  logic [CODE_W-1:0] optAck;
  logic csN, ackN, eclkReq;

  int nChecks = 0;
  int nFails = 0;
  int runLen = 0;
  bit done = 1'b0;

  chip_sel_opt #(.CODE_W(CODE_W)) i_chip_sel_opt (
    .clk(clk), .rstN(rstN), .addrHit(addrHit), .asN(asN), .dsN(dsN),
    .rdWr(rdWr), .byteLanes(byteLanes), .eclkPhase(eclkPhase),
    .port16(port16), .optSync(optSync), .optByte(optByte), .optRw(optRw),
    .optStrobe(optStrobe), .optAck(optAck), .csN(csN), .ackN(ackN),
    .eclkReq(eclkReq)
  );

  function automatic bit dirOk(logic [1:0] f, logic rd);
    return (f == 2'b11) || (f == 2'b01 && rd) || (f == 2'b10 && !rd);
  endfunction

  function automatic bit laneOk(logic p16, logic [1:0] f, logic [1:0] l);
    if (!p16) return 1'b1;
    return (f == 2'b01 && l[0]) || (f == 2'b10 && l[1]) || (f == 2'b11 && l != 2'b00);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic wrapUp();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // One clock: predict from the current inputs, step, compare at the negedge
  task automatic tick(string tag);
    bit qual, act, eCs, eAck, eReq;
    qual = addrHit && dirOk(optRw, rdWr) && laneOk(port16, optByte, byteLanes);
    if (!optSync) begin
      act = qual && (optStrobe ? !dsN : !asN);
      runLen = act ? runLen + 1 : 0;
      eCs  = !act;
      eAck = !(act && ((optAck == 4'b1110) ||
                       (optAck < 4'b1110 && runLen >= int'(optAck) + 2)));
      eReq = 1'b0;
    end else begin
      runLen = 0;
      eCs  = !(qual && !asN && eclkPhase);
      eAck = 1'b1;
      eReq = qual && !asN;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "csN", csN, eCs);
    chk(tag, "ackN", ackN, eAck);
    chk(tag, "eclkReq", eclkReq, eReq);
    if (!ackN && csN) begin
      nFails++;
      $display("FAIL R11 ack outside cs actual=ackN0/csN1 expected=not both");
    end
  endtask

  task automatic setOpt(logic s, logic [1:0] b, logic [1:0] rw, logic st,
                        logic [CODE_W-1:0] a, logic p);
    optSync = s; optByte = b; optRw = rw; optStrobe = st; optAck = a; port16 = p;
  endtask

  task automatic idle(string tag);
    asN = 1'b1; dsN = 1'b1;
    tick(tag);
  endtask

  task automatic hold(string tag, int n);
    asN = 1'b0; dsN = 1'b0;
    for (int i = 0; i < n; i++) tick(tag);
    idle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    wrapUp();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0; addrHit = 1'b0; asN = 1'b1; dsN = 1'b1; rdWr = 1'b1;
    byteLanes = 2'b00; eclkPhase = 1'b0;
    setOpt(1'b0, 2'b00, 2'b00, 1'b0, 4'b0000, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1", "csN", csN, 1'b1);
    chk("R1", "ackN", ackN, 1'b1);
    chk("R1", "eclkReq", eclkReq, 1'b0);
    rstN = 1'b1;

    // R2 direction qualifier
    addrHit = 1'b1; byteLanes = 2'b11;
    setOpt(1'b0, 2'b11, 2'b00, 1'b0, 4'd0, 1'b0);
    asN = 1'b0; rdWr = 1'b1; tick("R2");
    optRw = 2'b01; tick("R2");
    rdWr = 1'b0; tick("R2");
    optRw = 2'b10; tick("R2");
    optRw = 2'b11; rdWr = 1'b1; tick("R2");
    idle("R2");

    // R3 lane qualifier on a 16-bit port
    setOpt(1'b0, 2'b00, 2'b11, 1'b0, 4'd0, 1'b1);
    asN = 1'b0; byteLanes = 2'b11; tick("R3");
    optByte = 2'b01; byteLanes = 2'b10; tick("R3");
    byteLanes = 2'b01; tick("R3");
    idle("R3");
    optByte = 2'b10; byteLanes = 2'b10; asN = 1'b0; tick("R3");
    idle("R3");
    optByte = 2'b11; byteLanes = 2'b01; asN = 1'b0; tick("R3");
    idle("R3");

    // R4 lane field ignored on an 8-bit port
    setOpt(1'b0, 2'b00, 2'b11, 1'b0, 4'd0, 1'b0);
    byteLanes = 2'b00; asN = 1'b0; tick("R4");
    idle("R4");

    // R5 strobe selection
    setOpt(1'b0, 2'b11, 2'b11, 1'b1, 4'd2, 1'b0);
    asN = 1'b0; dsN = 1'b1; tick("R5");
    dsN = 1'b0; tick("R5"); tick("R5");
    dsN = 1'b1; tick("R5");
    asN = 1'b1; tick("R5");

    // R6 wait states, shortest, mid and longest
    optStrobe = 1'b0;
    optAck = 4'd0;  hold("R6", 4);
    optAck = 4'd3;  hold("R6", 8);
    optAck = 4'd13; hold("R6", 19);
    // R7 fast termination, R8 external acknowledge
    optAck = 4'b1110; hold("R7", 3);
    optAck = 4'b1111; hold("R8", 6);

    // R9 / R10 synchronous mode
    setOpt(1'b1, 2'b11, 2'b11, 1'b0, 4'b1110, 1'b0);
    asN = 1'b0; eclkPhase = 1'b0; tick("R10"); tick("R10");
    eclkPhase = 1'b1; tick("R9"); tick("R9");
    optAck = 4'd0; tick("R9");
    idle("R9");
    addrHit = 1'b0; asN = 1'b0; tick("R10");
    idle("R10");

    // Constrained random bus cycles
    for (int c = 0; c < 400; c++) begin
      setOpt(($urandom_range(3) == 0), 2'($urandom), 2'($urandom),
             1'($urandom), CODE_W'($urandom), 1'($urandom));
      addrHit   = ($urandom_range(9) != 0);
      rdWr      = 1'($urandom);
      byteLanes = 2'($urandom);
      asN = 1'b0; dsN = 1'b1;
      for (int k = 0, n = $urandom_range(18, 1); k < n; k++) begin
        eclkPhase = 1'($urandom);
        tick("R6");
        dsN = 1'b0;
      end
      if ($urandom_range(1) == 0) begin
        dsN = 1'b1; tick("R5");
      end
      idle("R5");
    end

    wrapUp();
  end
endmodule